// File: doc/BRIEF.md
# Reclaim Window Address Remapper

This block sits in the memory request path and moves addresses that lie above the top of installed memory back into the DRAM region hidden behind the hole below 4 GB. Each incoming 39-bit logical address has its megabyte number, bits [38:20], compared against a programmable window. When the address falls inside the window, its megabyte number is rebased onto the top-of-low-usable-memory boundary. An address outside the window is forwarded unchanged. The low 20 bits never take part in the arithmetic, so relocation always moves whole megabytes.

Firmware computes three boundaries and writes them, together with an enable bit, through a small register port. These are the window's first megabyte, its last megabyte and the top of low usable memory. A request enters on a valid/ready input. It leaves one cycle later on a valid/ready output that carries the translated address and a flag saying whether relocation was applied. A stalled output holds its contents until it is taken.

Top module: `remap_reclaim_top`

## Requirements
- R1: After a synchronous reset the window first page, last page, low-memory top and the enable bit all read back as zero, and `rsp_valid` is 0.
- R2: With the enable bit set, an address hits when its page field `addr[38:20]` is greater than or equal to the zero-extended 16-bit first page and less than or equal to the zero-extended 16-bit last page. Both ends count as inside.
- R3: On a hit, output bits [38:20] equal (page − first page + zero-extended 12-bit low-memory top), computed modulo 2^19, and `rsp_hit` is 1.
- R4: Output bits [19:0] equal input bits [19:0] for every request, hit or miss.
- R5: The register select `cfg_sel` picks 0 for the first page (data bits [35:20]), 1 for the last page (bits [35:20]), 2 for the low-memory top (bits [31:20]) and 3 for control (bit 0 = enable). Write data bits outside these fields are ignored and read back as zero.
- R6: On a miss the output address equals the input address and `rsp_hit` is 0.
- R7: When the first page is greater than the last page, no address hits.
- R8: A request accepted on a clock edge (`req_valid` and `req_ready` both high) shows on the output after that edge. `req_ready` is high whenever the output stage is empty or is being drained in the same cycle.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_addr` and `rsp_hit` stay constant and `rsp_valid` stays 1.
- R10: A request accepted on the same edge as a register write uses the old boundary values. Requests accepted on later edges use the new ones.
- R11: With the enable bit clear, no address hits, whatever the boundary values are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 39 | Logical address of the request |
| rsp_valid | output | 1 | Translated request present |
| rsp_ready | input | 1 | Downstream takes the translated request |
| rsp_addr | output | 39 | Translated DRAM address |
| rsp_hit | output | 1 | Relocation was applied to this request |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (see R5) |
| cfg_wdata | input | 39 | Register write data, fields at address bit positions |
| cfg_rdata | output | 39 | Read data of the selected register (combinational) |

## Verification
A request accepted on a rising edge must be on the output straight after that edge. The bench drives inputs at the falling edge and evaluates 1 ns later, before the next rising edge. At that point it decides which handshakes the coming edge completes and pushes the expected result into a queue, and the queue head is compared with the output on every following cycle until it is taken. Register read data is combinational and is checked in the same cycle it is selected. A write changes the model's boundaries only after the request handshake of the same edge has been recorded, which gives the one-edge delay of R10.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int ADDR_W   = 39;              // logical / DRAM address width
    localparam int PAGE_LSB = 20;              // 1 MB granularity
    localparam int WIN_HI   = 35;              // top bit of window registers
    localparam int TOP_HI   = 31;              // top bit of low-memory top register
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;
    localparam int WIN_W    = WIN_HI - PAGE_LSB + 1;
    localparam int TOP_W    = TOP_HI - PAGE_LSB + 1;
    localparam int SEL_W    = 2;

    typedef logic [PAGE_W-1:0] page_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_FIRST = 2'd0,
        SEL_LAST  = 2'd1,
        SEL_TOP   = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             enable;
        logic [WIN_W-1:0] first_pg;
        logic [WIN_W-1:0] last_pg;
        logic [TOP_W-1:0] top_pg;
    } bounds_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              hit;
    } xreq_t;

    function automatic page_t widen_win(input logic [WIN_W-1:0] v);
        return {{(PAGE_W-WIN_W){1'b0}}, v};
    endfunction

    function automatic page_t widen_top(input logic [TOP_W-1:0] v);
        return {{(PAGE_W-TOP_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/remap_bound_regs.sv
module remap_bound_regs
    import remap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [SEL_W-1:0]      sel,
    input  logic [ADDR_W-1:0]     wdata,
    output logic [ADDR_W-1:0]     rdata,
    output bounds_t               bounds
);
    reg_sel_e sel_e;
    assign sel_e = reg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            bounds <= '0;
        end else if (we) begin
            case (sel_e)
                SEL_FIRST: bounds.first_pg <= wdata[WIN_HI:PAGE_LSB];
                SEL_LAST:  bounds.last_pg  <= wdata[WIN_HI:PAGE_LSB];
                SEL_TOP:   bounds.top_pg   <= wdata[TOP_HI:PAGE_LSB];
                SEL_CTRL:  bounds.enable   <= wdata[0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel_e)
            SEL_FIRST: rdata[WIN_HI:PAGE_LSB] = bounds.first_pg;
            SEL_LAST:  rdata[WIN_HI:PAGE_LSB] = bounds.last_pg;
            SEL_TOP:   rdata[TOP_HI:PAGE_LSB] = bounds.top_pg;
            SEL_CTRL:  rdata[0]               = bounds.enable;
            default:   ;
        endcase
    end

    // Bits outside every field are dropped on purpose (R5).
    logic unused_wbits;
    assign unused_wbits = ^{wdata[ADDR_W-1:WIN_HI+1], wdata[PAGE_LSB-1:1]};

    // R5: low-memory top never carries bits above its field after a write
    p_top_field_r5: assert property (@(posedge clk) disable iff (rst)
        we && sel_e == SEL_TOP |=> bounds.top_pg == $past(wdata[TOP_HI:PAGE_LSB]));
endmodule

// File: rtl/remap_window_xlate.sv
module remap_window_xlate
    import remap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  bounds_t           bounds,
    output xreq_t             result
);
    page_t pg, first_w, last_w, top_w, moved;
    logic  in_win;

    always_comb begin
        pg      = addr[ADDR_W-1:PAGE_LSB];
        first_w = widen_win(bounds.first_pg);
        last_w  = widen_win(bounds.last_pg);
        top_w   = widen_top(bounds.top_pg);
        in_win  = bounds.enable && (pg >= first_w) && (pg <= last_w);
        moved   = pg - first_w + top_w;   // carry out of bit 38 dropped
        result.hit  = in_win;
        result.addr = in_win ? {moved, addr[PAGE_LSB-1:0]} : addr;
    end
endmodule

// File: rtl/remap_out_stage.sv
module remap_out_stage
    import remap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    input  xreq_t in_data,
    output logic  out_valid,
    input  logic  out_ready,
    output xreq_t out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end

    // R9: stalled output holds
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8: accepted request appears after the accepting edge
    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid && out_data == $past(in_data));
endmodule

// File: rtl/remap_reclaim_top.sv
module remap_reclaim_top
    import remap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [ADDR_W-1:0]    rsp_addr,
    output logic                 rsp_hit,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    output logic [ADDR_W-1:0]    cfg_rdata
);
    bounds_t bounds;
    xreq_t   xlated, held;

    remap_bound_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .bounds(bounds)
    );

    remap_window_xlate u_xlate (
        .addr(req_addr), .bounds(bounds), .result(xlated)
    );

    remap_out_stage u_stage (
        .clk(clk), .rst(rst),
        .in_valid(req_valid), .in_ready(req_ready), .in_data(xlated),
        .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(held)
    );

    assign rsp_addr = held.addr;
    assign rsp_hit  = held.hit;

    logic accept;
    assign accept = req_valid && req_ready;

    // R1: output empty right after reset
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid && bounds == '0);

    // R4: low 20 bits always pass through
    p_low_bits_r4: assert property (@(posedge clk) disable iff (rst)
        accept |=> rsp_addr[PAGE_LSB-1:0] == $past(req_addr[PAGE_LSB-1:0]));

    // R6: a miss leaves the address untouched
    p_miss_passthru_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> rsp_hit || rsp_addr == $past(req_addr));

    // R7: inverted window never hits
    p_inverted_window_r7: assert property (@(posedge clk) disable iff (rst)
        accept && bounds.first_pg > bounds.last_pg |=> !rsp_hit);

    // R11: disabled window never hits
    p_disabled_r11: assert property (@(posedge clk) disable iff (rst)
        accept && !bounds.enable |=> !rsp_hit);
endmodule

// File: tb/remap_reclaim_top_tb.sv
`timescale 1ns/1ps
module remap_reclaim_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [38:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [38:0] rsp_addr;
    logic        rsp_hit;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [38:0] cfg_wdata = '0;
    logic [38:0] cfg_rdata;

    always #2.5 clk = ~clk;

    remap_reclaim_top u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_hit(rsp_hit), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    string cur_req  = "R3";

    // reference model state
    longint unsigned m_first = 0, m_last = 0, m_top = 0;
    bit              m_en = 0;
    logic [38:0]     exp_addr_q[$];
    bit              exp_hit_q[$];

    task automatic check(input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_xlate(input logic [38:0] a, output logic [38:0] o, output bit h);
        longint unsigned pg = a >> 20;
        h = m_en && pg >= m_first && pg <= m_last;
        if (h) o = 39'({(pg - m_first + m_top) % (64'd1 << 19), a[19:0]});
        else   o = a;
    endtask

    task automatic model_write(input logic [1:0] s, input logic [38:0] d);
        case (s)
            2'd0: m_first = (d >> 20) & 64'hFFFF;
            2'd1: m_last  = (d >> 20) & 64'hFFFF;
            2'd2: m_top   = (d >> 20) & 64'hFFF;
            default: m_en = d[0];
        endcase
    endtask

    // evaluate one cycle: inputs were driven at the falling edge
    task automatic step();
        logic [38:0] ea;
        bit          eh;
        #1;
        check("R8", "rsp_valid", rsp_valid, exp_addr_q.size() > 0);
        if (rsp_valid && exp_addr_q.size() > 0) begin
            check(exp_hit_q[0] ? cur_req : "R6", "rsp_addr", rsp_addr, exp_addr_q[0]);
            check(cur_req, "rsp_hit", rsp_hit, exp_hit_q[0]);
            check("R4", "low bits", rsp_addr[19:0], exp_addr_q[0][19:0]);
        end
        if (rsp_valid && rsp_ready && exp_addr_q.size() > 0) begin
            void'(exp_addr_q.pop_front());
            void'(exp_hit_q.pop_front());
        end
        if (req_valid && req_ready) begin
            model_xlate(req_addr, ea, eh);
            exp_addr_q.push_back(ea);
            exp_hit_q.push_back(eh);
        end
        if (cfg_we) model_write(cfg_sel, cfg_wdata);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [38:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] s, input logic [38:0] exp);
        cfg_sel = s;
        #1;
        check(tag, "cfg_rdata", cfg_rdata, exp);
    endtask

    task automatic send(input logic [38:0] a);
        req_valid = 1'b1; req_addr = a;
        step();
        req_valid = 1'b0;
    endtask

    function automatic logic [38:0] pga(input int unsigned pg, input int unsigned lo);
        return {19'(pg), 20'(lo)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed = 32'h1234_5678;
        logic [38:0] held_a;
        logic        held_h;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int s = 0; s < 4; s++) rd_check("R1", 2'(s), '0);
        cur_req = "R1";
        step();

        // R5: register map, stray bits ignored
        cfg_write(2'd0, 39'h70_0000_0000 | pga(16'h1000, 20'hFFFFF));
        cfg_write(2'd1, pga(16'h13FF, 20'h12345));
        cfg_write(2'd2, pga(19'h70C00, 20'hABCDE));
        cfg_write(2'd3, 39'h7F_FFFF_FFFF);
        rd_check("R5", 2'd0, pga(16'h1000, 0));
        rd_check("R5", 2'd1, pga(16'h13FF, 0));
        rd_check("R5", 2'd2, pga(12'hC00, 0));
        rd_check("R5", 2'd3, 39'd1);

        // R2 / R3: inclusive bounds and relocation
        cur_req = "R2";
        send(pga(16'h0FFF, 20'h0F00D));
        send(pga(16'h1000, 20'h00001));
        send(pga(16'h13FF, 20'hFFFFF));
        send(pga(16'h1400, 20'h55555));
        cur_req = "R3";
        send(pga(16'h1234, 20'hABCDE));
        send(pga(19'h7FFFF, 20'h00000));
        step();

        // R9: stall holds output
        cur_req = "R9";
        rsp_ready = 1'b0;
        send(pga(16'h1100, 20'h00042));
        held_a = rsp_addr; held_h = rsp_hit;
        req_valid = 1'b1; req_addr = pga(16'h0001, 20'h1);
        for (int i = 0; i < 3; i++) begin
            step();
            check("R9", "held addr", rsp_addr, held_a);
            check("R9", "held hit", rsp_hit, held_h);
            check("R9", "req_ready low", req_ready, 1'b0);
        end
        rsp_ready = 1'b1;
        step();
        req_valid = 1'b0;
        step(); step();

        // R10: write and request on the same edge
        cur_req = "R10";
        req_valid = 1'b1; req_addr = pga(16'h1400, 20'h777);
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = pga(16'h1400, 0);
        step();
        cfg_we = 1'b0;
        step();
        req_valid = 1'b0;
        step();

        // R7: inverted window
        cur_req = "R7";
        cfg_write(2'd0, pga(16'h2000, 0));
        cfg_write(2'd1, pga(16'h1000, 0));
        send(pga(16'h1800, 20'h1));
        send(pga(16'h2000, 20'h2));
        send(pga(16'h1000, 20'h3));
        step();

        // R11: disabled window
        cur_req = "R11";
        cfg_write(2'd0, pga(16'h0000, 0));
        cfg_write(2'd1, pga(16'hFFFF, 0));
        cfg_write(2'd3, 39'd0);
        send(pga(16'h0000, 20'h9));
        send(pga(16'h8000, 20'hA));
        cfg_write(2'd3, 39'd1);
        send(pga(16'h8000, 20'hA));
        step();

        // mixed traffic with random stalls and occasional writes
        cur_req = "R3";
        for (int i = 0; i < 400; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            req_valid = seed[3];
            rsp_ready = seed[5] | seed[6];
            req_addr  = seed[15] ? pga(32'h0FF0 + 32'(seed[26:17]), 32'(seed[31:12]))
                                 : {seed[31:13], seed[19:0]};
            cfg_we = (seed[10:7] == 4'd0);
            cfg_sel = seed[12:11];
            cfg_wdata = pga(32'h0F00 + 32'(seed[24:16]), 32'(seed[30:14]));
            if (seed[12:11] == 2'd3) cfg_wdata[0] = seed[25] | seed[26];
            step();
        end
        req_valid = 1'b0; cfg_we = 1'b0; rsp_ready = 1'b1;
        step(); step();

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule